// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, for every incoming frame, whether to keep it. It watches the byte stream from the start of the frame and collects the six octets of the destination address. While those octets arrive, it computes the CRC-32 of the address on the fly. Once the sixth octet has been taken in, it registers a single accept or reject decision. That decision stays valid until the next frame begins, so the downstream frame store can act on it long before the end of the frame.

Filtering works on four sources:
- two exact-match station addresses, the second of which can be switched off by writing zero;
- a multicast hash table with 2^HASH_BITS single-bit entries, indexed by the top bits of the address CRC;
- a fixed rule that always accepts broadcast;
- a promiscuous mode that accepts everything.

All settings are loaded through one word-wide write port with a 3-bit register select.

Top module: `rx_da_filter`

## Requirements
- R1: With the mode bit (select code 0, data bit 0) set, every frame is accepted. The mode bit is 0 after reset.
- R2: With promiscuous mode off, a unicast frame (bit 0 of octet 0 is 0) is accepted only when its destination equals the primary or the secondary station address.
- R3: Station registers use these select codes: 1 is primary low, 2 is primary high, 3 is secondary low, 4 is secondary high. Octet 0 maps to bits 7:0 of the low word, octet 3 to bits 31:24 of the low word, and octets 4 and 5 to bits 7:0 and 15:8 of the high word. Select code 7 changes nothing.
- R4: A secondary station address of all zeros never matches.
- R5: A write with select code 5 sets hash entry `wdata[8:0]` to the value of `wdata[9]`.
- R6: The hash index is bits 31:23 of the CRC-32 of the six destination octets. The CRC uses the reflected polynomial 0xEDB88320, processes bits LSB first, starts at all ones and is complemented at the end.
- R7: A multicast frame (bit 0 of octet 0 is 1) that is not broadcast is accepted only when its hash entry is 1.
- R8: The broadcast address FF:FF:FF:FF:FF:FF is always accepted.
- R9: A write with select code 6 clears every hash entry, whatever the data.
- R10: A byte with `rx_valid` and `rx_sof` high is octet 0. `dec_valid` is low in the cycle after it. `dec_valid` and `dec_accept` are updated at the clock edge that takes in octet 5. They then hold until the next start byte. Bytes after octet 5 are ignored, and so are bytes received after reset before any start byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | WORD_W (32) | Configuration write data |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_byte | input | 8 | Receive byte |
| dec_valid | output | 1 | Decision for the current frame is available |
| dec_accept | output | 1 | 1 = keep the frame, 0 = drop it |

## Verification
Several internal faults show up within one frame at `dec_accept`, one clock after octet 5:
- a corrupted byte position inside the address shift register;
- a wrong CRC bit order;
- a misplaced hash index.

In each case the expected set of accepted addresses changes. A hash or station register that is written wrongly stays hidden until a frame aims at the affected entry. The bench therefore follows each write with frames that target the written entry, and with frames that target its neighbours. A counter fault in the octet capture moves the cycle in which `dec_valid` rises. Sampling one clock after octet 5, and again after trailing bytes, exposes this immediately.

// File: rtl/rx_da_pkg.sv
package rx_da_pkg;

   localparam int OCTETS = 6;
   localparam int ADDR_W = 8 * OCTETS;
   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

   typedef enum logic [2:0] {
      SEL_MODE  = 3'd0,
      SEL_P_LO  = 3'd1,
      SEL_P_HI  = 3'd2,
      SEL_S_LO  = 3'd3,
      SEL_S_HI  = 3'd4,
      SEL_HASH  = 3'd5,
      SEL_CLR   = 3'd6,
      SEL_NONE  = 3'd7
   } cfg_sel_e;

   // One byte through the reflected CRC-32, least significant bit first.
   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
      logic [31:0] r;
      r = c;
      for (int k = 0; k < 8; k++) begin
         if (r[0] ^ b[k]) r = (r >> 1) ^ CRC_POLY_REFL;
         else             r = r >> 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/rx_da_capture.sv
module rx_da_capture
   import rx_da_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic [7:0]        in_byte,
   output logic              last_stb,
   output logic [ADDR_W-1:0] addr_nxt,
   output logic [31:0]       crc_nxt
);
   localparam int CNT_W = $clog2(OCTETS + 1);
   localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(OCTETS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OCTETS - 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  pos;
   logic [31:0]       crc_q;
   logic [ADDR_W-1:0] addr_q;
   logic              take;

   assign take     = in_valid && (in_sof || (cnt_q != CNT_DONE));
   assign pos      = in_sof ? '0 : cnt_q;
   assign last_stb = in_valid && !in_sof && (cnt_q == CNT_LAST);

   always_comb begin
      crc_nxt  = crc_step(in_sof ? 32'hFFFF_FFFF : crc_q, in_byte);
      addr_nxt = in_sof ? '0 : addr_q;
      for (int i = 0; i < OCTETS; i++) begin
         if (pos == CNT_W'(i)) addr_nxt[8*i +: 8] = in_byte;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= CNT_DONE;
         crc_q  <= '1;
         addr_q <= '0;
      end else if (take) begin
         cnt_q  <= pos + 1'b1;
         crc_q  <= crc_nxt;
         addr_q <= addr_nxt;
      end
   end

   // R10: a start byte always restarts the octet count
   a_r10_sof_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |=> (cnt_q == CNT_W'(1)));

   // R10: once all octets are in, further non-start bytes leave the capture untouched
   a_r10_tail_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_DONE && !(in_valid && in_sof)) |=> ($stable(addr_q) && $stable(crc_q)));

endmodule

// File: rtl/rx_da_cfg.sv
module rx_da_cfg
   import rx_da_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int HASH_BITS = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [2:0]           sel,
   input  logic [WORD_W-1:0]    wdata,
   input  logic [HASH_BITS-1:0] hash_idx,
   output logic                 promisc,
   output logic [ADDR_W-1:0]    sta_pri,
   output logic [ADDR_W-1:0]    sta_sec,
   output logic                 hash_hit
);
   localparam int HI_W    = ADDR_W - WORD_W;
   localparam int ENTRIES = 1 << HASH_BITS;

   logic [ENTRIES-1:0] tbl;

   assign hash_hit = tbl[hash_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         promisc <= 1'b0;
         sta_pri <= '0;
         sta_sec <= '0;
         tbl     <= '0;
      end else if (we) begin
         case (cfg_sel_e'(sel))
            SEL_MODE: promisc                   <= wdata[0];
            SEL_P_LO: sta_pri[WORD_W-1:0]       <= wdata;
            SEL_P_HI: sta_pri[ADDR_W-1:WORD_W]  <= wdata[HI_W-1:0];
            SEL_S_LO: sta_sec[WORD_W-1:0]       <= wdata;
            SEL_S_HI: sta_sec[ADDR_W-1:WORD_W]  <= wdata[HI_W-1:0];
            SEL_HASH: tbl[wdata[HASH_BITS-1:0]] <= wdata[HASH_BITS];
            SEL_CLR:  tbl                       <= '0;
            default:  ;
         endcase
      end
   end

   // R9: a clear-all write empties the table
   a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_CLR) |=> (tbl == '0));

   // R5: an entry write lands at the addressed index with the requested value
   a_r5_entry_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_HASH) |=> (tbl[$past(wdata[HASH_BITS-1:0])] == $past(wdata[HASH_BITS])));

   // R1: the mode bit changes only through its own select code
   a_r1_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && sel == SEL_MODE) |=> $stable(promisc));

endmodule

// File: rtl/rx_da_match.sv
module rx_da_match
   import rx_da_pkg::*;
#(
   parameter bit ZERO_OFF = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] station,
   output logic              hit
);
   generate
      if (ZERO_OFF) begin : g_gated
         assign hit = (station != '0) && (addr == station);
      end else begin : g_plain
         assign hit = (addr == station);
      end
   endgenerate

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
   import rx_da_pkg::*;
#(
   parameter int WORD_W       = 32,
   parameter int HASH_BITS    = 9,
   parameter bit SEC_ZERO_OFF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic [7:0]        rx_byte,
   output logic              dec_valid,
   output logic              dec_accept
);
   localparam int NUM_STA = 2;

   generate
      if (HASH_BITS < 1 || HASH_BITS > 12) begin : g_bad_hash
         $error("HASH_BITS must be in 1..12");
      end
      if (WORD_W < 24 || WORD_W >= ADDR_W) begin : g_bad_word
         $error("WORD_W must be in 24..47");
      end
      if (HASH_BITS + 1 > WORD_W) begin : g_bad_ctl
         $error("hash control word does not fit in WORD_W");
      end
   endgenerate

   logic                 last_stb;
   logic [ADDR_W-1:0]    addr_nxt;
   logic [31:0]          crc_nxt;
   logic [31:0]          crc_fin;
   logic [HASH_BITS-1:0] hash_idx;
   logic                 promisc;
   logic                 hash_hit;
   logic [NUM_STA-1:0][ADDR_W-1:0] sta;
   logic [NUM_STA-1:0]   sta_hit;
   logic                 is_mcast;
   logic                 is_bcast;
   logic                 accept_d;
   logic                 frame_start;

   rx_da_capture u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (rx_valid),
      .in_sof   (rx_sof),
      .in_byte  (rx_byte),
      .last_stb (last_stb),
      .addr_nxt (addr_nxt),
      .crc_nxt  (crc_nxt)
   );

   assign crc_fin  = ~crc_nxt;
   assign hash_idx = crc_fin[31 -: HASH_BITS];

   rx_da_cfg #(.WORD_W(WORD_W), .HASH_BITS(HASH_BITS)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .sel      (cfg_sel),
      .wdata    (cfg_wdata),
      .hash_idx (hash_idx),
      .promisc  (promisc),
      .sta_pri  (sta[0]),
      .sta_sec  (sta[1]),
      .hash_hit (hash_hit)
   );

   generate
      for (genvar g = 0; g < NUM_STA; g++) begin : g_sta
         rx_da_match #(.ZERO_OFF((g != 0) && SEC_ZERO_OFF)) u_match (
            .addr    (addr_nxt),
            .station (sta[g]),
            .hit     (sta_hit[g])
         );
      end
   endgenerate

   assign is_mcast    = addr_nxt[0];
   assign is_bcast    = &addr_nxt;
   assign accept_d    = promisc || is_bcast || (is_mcast ? hash_hit : (|sta_hit));
   assign frame_start = rx_valid && rx_sof;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
      end else if (frame_start) begin
         dec_valid  <= 1'b0;
      end else if (last_stb) begin
         dec_valid  <= 1'b1;
         dec_accept <= accept_d;
      end
   end

   // R10: the decision appears right after the last address octet
   a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      last_stb |=> dec_valid);

   // R10: a new frame withdraws the previous decision
   a_r10_sof_clear: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !dec_valid);

   // R10: a published decision holds until the next start byte
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !frame_start) |=> (dec_valid && $stable(dec_accept)));

   // R8: broadcast is always kept
   a_r8_bcast: assert property (@(posedge clk) disable iff (!rst_n)
      (last_stb && is_bcast) |=> dec_accept);

   // R1: promiscuous mode keeps every frame
   a_r1_promisc: assert property (@(posedge clk) disable iff (!rst_n)
      (last_stb && promisc) |=> dec_accept);

   // R4: a zero secondary station never produces a hit
   a_r4_sec_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sta[1] == '0 && SEC_ZERO_OFF) |-> !sta_hit[1]);

endmodule

// File: tb/rx_da_filter_tb.sv
module rx_da_filter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = 3'd0;
   logic [31:0] cfg_wdata = 32'd0;
   logic        rx_valid = 1'b0;
   logic        rx_sof = 1'b0;
   logic [7:0]  rx_byte = 8'd0;
   logic        dec_valid;
   logic        dec_accept;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // bench-side model of the configuration
   bit         m_promisc = 1'b0;
   bit [47:0]  m_pri = '0;
   bit [47:0]  m_sec = '0;
   bit [511:0] m_tbl = '0;

   always #2.5 clk = ~clk;

   rx_da_filter u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_byte(rx_byte),
      .dec_valid(dec_valid), .dec_accept(dec_accept)
   );

   function automatic bit [8:0] hash_of(input bit [47:0] a);
      bit [31:0] c;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < 6; i++) begin
         for (int k = 0; k < 8; k++) begin
            if (c[0] ^ a[8*i + k]) c = (c >> 1) ^ 32'hEDB8_8320;
            else                   c = c >> 1;
         end
      end
      c = ~c;
      return c[31:23];
   endfunction

   function automatic bit expect_accept(input bit [47:0] a);
      if (m_promisc) return 1'b1;
      if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
      if (a[0]) return m_tbl[hash_of(a)];
      return (a == m_pri) || (m_sec != 48'd0 && a == m_sec);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
      case (sel)
         3'd0: m_promisc = data[0];
         3'd1: m_pri[31:0] = data;
         3'd2: m_pri[47:32] = data[15:0];
         3'd3: m_sec[31:0] = data;
         3'd4: m_sec[47:32] = data[15:0];
         3'd5: m_tbl[data[8:0]] = data[9];
         3'd6: m_tbl = '0;
         default: ;
      endcase
   endtask

   task automatic set_station(input bit sec, input bit [47:0] a);
      cfg_write(sec ? 3'd3 : 3'd1, a[31:0]);
      cfg_write(sec ? 3'd4 : 3'd2, {16'h0, a[47:32]});
   endtask

   task automatic send_frame(input string req, input bit [47:0] a, input int tail);
      bit exp;
      exp = expect_accept(a);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (i == 1) chk("R10 valid low after start", dec_valid, 1'b0);
         rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = a[8*i +: 8];
      end
      @(negedge clk);
      chk("R10 valid after octet 5", dec_valid, 1'b1);
      chk(req, dec_accept, exp);
      rx_valid = 1'b0; rx_sof = 1'b0;
      if (tail > 0) begin
         for (int t = 0; t < tail; t++) begin
            rx_valid = 1'b1; rx_byte = 8'($urandom);
            @(negedge clk);
         end
         rx_valid = 1'b0;
         chk("R10 decision holds over trailing bytes", {dec_valid, dec_accept}, {1'b1, exp});
      end
   endtask

   function automatic bit [47:0] rnd_addr();
      return {16'($urandom), 32'($urandom)};
   endfunction

   initial begin : wd
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      bit [47:0] a, p, s, m, m2;
      bit [8:0]  h;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset dec_valid", dec_valid, 1'b0);
      chk("R10 reset dec_accept", dec_accept, 1'b0);

      // stray bytes before any start byte do nothing
      rx_valid = 1'b1; rx_byte = 8'h55;
      repeat (8) @(negedge clk);
      rx_valid = 1'b0;
      chk("R10 stray bytes ignored", dec_valid, 1'b0);

      a = rnd_addr(); a[0] = 1'b0; a[47] = 1'b1;
      send_frame("R1 promiscuous off after reset", a, 0);

      p = 48'h5634_1200_AB02; s = 48'h0000_0000_0000;
      p = rnd_addr(); p[0] = 1'b0;
      s = rnd_addr(); s[0] = 1'b0;
      set_station(1'b0, p);
      set_station(1'b1, s);
      send_frame("R2 R3 primary match", p, 2);
      send_frame("R2 R3 secondary match", s, 1);
      a = p; a[47:40] = ~a[47:40];
      send_frame("R2 R3 octet 5 mismatch", a, 0);
      a = p; a[15:8] = ~a[15:8];
      send_frame("R2 R3 octet 1 mismatch", a, 0);

      set_station(1'b1, 48'd0);
      send_frame("R4 zero secondary never matches", 48'd0, 0);
      send_frame("R4 old secondary rejected", s, 0);

      send_frame("R8 broadcast", 48'hFFFF_FFFF_FFFF, 1);

      m = rnd_addr(); m[0] = 1'b1;
      h = hash_of(m);
      send_frame("R7 R6 multicast empty table", m, 0);
      cfg_write(3'd5, {22'd0, 1'b1, h});
      send_frame("R5 R6 R7 multicast entry set", m, 0);
      m2 = m; m2[40] = ~m2[40];
      if (hash_of(m2) != h) send_frame("R6 R7 neighbour entry clear", m2, 0);
      cfg_write(3'd5, {22'd0, 1'b0, h});
      send_frame("R5 entry cleared by bit9=0", m, 0);

      for (int i = 0; i < 8; i++) cfg_write(3'd5, {22'd0, 1'b1, 9'($urandom)});
      cfg_write(3'd5, {22'd0, 1'b1, h});
      send_frame("R5 R7 entry set again", m, 0);
      cfg_write(3'd6, 32'hFFFF_FFFF);
      send_frame("R9 clear all", m, 0);

      cfg_write(3'd7, 32'hFFFF_FFFF);
      a = rnd_addr(); a[0] = 1'b0; a[46] = ~p[46];
      send_frame("R3 select 7 has no effect", a, 0);
      send_frame("R3 primary still set after select 7", p, 0);

      cfg_write(3'd0, 32'd1);
      a = rnd_addr(); a[0] = 1'b0;
      send_frame("R1 promiscuous unicast", a, 0);
      a[0] = 1'b1;
      send_frame("R1 promiscuous multicast", a, 0);
      cfg_write(3'd0, 32'd0);

      for (int it = 0; it < 250; it++) begin
         int op;
         op = int'($urandom_range(0, 19));
         if (op < 12) begin
            int kind;
            kind = int'($urandom_range(0, 4));
            a = rnd_addr();
            case (kind)
               0: a = m_pri;
               1: a = m_sec;
               2: a[0] = 1'b0;
               3: a[0] = 1'b1;
               default: a = 48'hFFFF_FFFF_FFFF;
            endcase
            send_frame(m_promisc ? "R1 random frame" :
                       (a == 48'hFFFF_FFFF_FFFF) ? "R8 random frame" :
                       a[0] ? "R6 R7 random frame" :
                       (m_sec == 48'd0 && a == 48'd0) ? "R4 random frame" : "R2 random frame",
                       a, int'($urandom_range(0, 3)));
         end else if (op < 16) begin
            cfg_write(3'd5, {22'd0, 1'($urandom), 9'($urandom)});
         end else if (op == 16) begin
            a = rnd_addr(); a[0] = 1'b0;
            set_station(1'($urandom), ($urandom_range(0, 3) == 0) ? 48'd0 : a);
         end else if (op == 17) begin
            cfg_write(3'd0, {31'd0, ($urandom_range(0, 3) == 0)});
         end else if (op == 18) begin
            if ($urandom_range(0, 3) == 0) cfg_write(3'd6, 32'($urandom));
         end else begin
            cfg_write(3'd7, 32'($urandom));
         end
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule